// File: doc/BRIEF.md
# Interlocked Five-Step In-Order Core

This block is a small in-order processor core with five stages: fetch, decode, memory read, execute and write-back. The memory-read stage comes before the ALU, so a direct-address load gets its operand in stage three. A store also writes memory in stage three. There are no forwarding paths. Every register dependency and every conditional branch is resolved by holding the dependent instruction in decode and sending empty slots (bubbles) down the pipe behind it.

The pipeline advances one stage every two clocks. A free-running cycle counter freezes when the core halts, so the total cycles a program takes can be compared against a schedule worked out by hand. Instruction and data memories sit outside the core. Fetch, data read and data write each have their own port, so fetch never contends with a data access.

Top module: `stallpipe_core`

## Requirements
- R1: Instructions use a 32-bit word. Bits [31:28] are the opcode, [27:24] the destination register, [23:20] the first source, [19:16] the second source, and [15:0] a direct address or branch target. The opcodes are NOP=0, LOAD=1, STORE=2, ADD=3, XOR=4, AND=5, BNEZ=6, BEZ=7 and END=15.
- R2: The pipeline advances once every two clocks. Fetch-address changes and data-memory writes happen only on those step edges. A write strobe lasts a single clock.
- R3: LOAD places data memory at its direct address into the destination register. The read address is presented while the load occupies the memory-read stage.
- R4: STORE writes the first-source register to its direct address. It does this during the step in which it occupies the memory-read stage.
- R5: ADD, XOR and AND combine the two source registers and write the destination register. ADD uses 32-bit wrap-around.
- R6: An instruction whose source register is the destination of an older instruction still in memory read, execute or write-back waits in decode. A bubble enters the pipe for each waiting step. An instruction directly behind its producer therefore loses three steps.
- R7: A register written in write-back is seen by decode only from the next step onward. An instruction waiting on a producer in write-back still waits for that step.
- R8: BNEZ branches to its target when its register is non-zero. BEZ branches when its register is zero. Otherwise execution falls through.
- R9: After a branch is decoded, no further instruction is fetched until the branch leaves decode. A skipped instruction never writes memory. Each branch, taken or not, adds exactly one bubble.
- R10: Decoding END stops all further fetch. The halt output rises on the step edge after END has spent its step in write-back, and it stays high.
- R11: The cycle counter adds one on every clock from reset until halt. It includes the clock on which halt rises, and it is frozen afterwards.
- R12: During reset the halt output, cycle counter, fetch address and write strobe are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 16 | Fetch address (word index) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_re | output | 1 | Load in the memory-read stage |
| dmem_raddr | output | 16 | Data read address |
| dmem_rdata | input | 32 | Data word at `dmem_raddr` |
| dmem_we | output | 1 | Data write strobe |
| dmem_waddr | output | 16 | Data write address |
| dmem_wdata | output | 32 | Data write value |
| halted | output | 1 | Core has halted |
| cycle_count | output | 32 | Clocks elapsed until halt |

## Verification
Two things can land on the same step edge: a register file write from write-back and the decode read of a consumer waiting on that same register. The interlock must make the consumer wait through that step. Programs place a consumer directly behind a load or ALU producer, and a store makes the consumer's result visible in data memory. A failure shows up either as a stale value stored to memory or as a final cycle count that differs from the hand-derived schedule. Branch programs also check that a skipped store leaves its preset memory word untouched.

// File: rtl/stallpipe_pkg.sv
package stallpipe_pkg;

    localparam int INSTR_W = 32;
    localparam int OP_MSB  = 31;
    localparam int RD_MSB  = 27;
    localparam int RS1_MSB = 23;
    localparam int RS2_MSB = 19;
    localparam int FLD_W   = 4;
    localparam int IMM_W   = 16;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADD   = 4'h3,
        OP_XOR   = 4'h4,
        OP_AND   = 4'h5,
        OP_BNEZ  = 4'h6,
        OP_BEZ   = 4'h7,
        OP_END   = 4'hF
    } op_e;

    function automatic logic op_writes_rd(op_e op);
        return op inside {OP_LOAD, OP_ADD, OP_XOR, OP_AND};
    endfunction

    function automatic logic op_reads_rs1(op_e op);
        return op inside {OP_STORE, OP_ADD, OP_XOR, OP_AND, OP_BNEZ, OP_BEZ};
    endfunction

    function automatic logic op_reads_rs2(op_e op);
        return op inside {OP_ADD, OP_XOR, OP_AND};
    endfunction

    function automatic logic op_is_branch(op_e op);
        return op inside {OP_BNEZ, OP_BEZ};
    endfunction

endpackage

// File: rtl/stallpipe_regfile.sv
module stallpipe_regfile #(
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra1,
    input  logic [IDX_W-1:0]  ra2,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2
);
    logic [DATA_W-1:0] regs_q [NREG];

    // Reads return the stored value; a write on the same edge is not bypassed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];
endmodule

// File: rtl/stallpipe_hazard.sv
module stallpipe_hazard
    import stallpipe_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int NDST  = 3
) (
    input  logic                       id_valid,
    input  op_e                        id_op,
    input  logic [IDX_W-1:0]           id_rs1,
    input  logic [IDX_W-1:0]           id_rs2,
    input  logic [NDST-1:0]            dst_valid,
    input  logic [NDST-1:0][IDX_W-1:0] dst_idx,
    output logic                       stall
);
    logic [NDST-1:0] hit;

    // One comparator pair per in-flight stage that may still write a register.
    for (genvar g = 0; g < NDST; g++) begin : g_cmp
        assign hit[g] = dst_valid[g] &&
                        ((op_reads_rs1(id_op) && (dst_idx[g] == id_rs1)) ||
                         (op_reads_rs2(id_op) && (dst_idx[g] == id_rs2)));
    end

    assign stall = id_valid && (|hit);
endmodule

// File: rtl/stallpipe_alu.sv
module stallpipe_alu
    import stallpipe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_XOR:  y = a ^ b;
            OP_AND:  y = a & b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/stallpipe_core.sv
module stallpipe_core
    import stallpipe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = IMM_W,
    parameter int NREG   = 16,
    parameter int CNT_W  = 32,
    localparam int IDX_W = $clog2(NREG),
    localparam int NDST  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic              dmem_re,
    output logic [ADDR_W-1:0] dmem_raddr,
    input  logic [DATA_W-1:0] dmem_rdata,
    output logic              dmem_we,
    output logic [ADDR_W-1:0] dmem_waddr,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic              halted,
    output logic [CNT_W-1:0]  cycle_count
);
    typedef struct packed {
        logic              valid;
        op_e               op;
        logic [IDX_W-1:0]  rd;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] res;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    typedef struct packed {
        logic               phase;
        logic               halt;
        logic               stop;
        logic [ADDR_W-1:0]  pc;
        logic               id_valid;
        logic [INSTR_W-1:0] id_instr;
        stage_t             mr;
        stage_t             ex;
        stage_t             wb;
        logic [CNT_W-1:0]   count;
    } state_t;

    state_t state_q, state_d;

    // Decode fields of the instruction waiting in decode.
    op_e               id_op;
    logic [IDX_W-1:0]  id_rd, id_rs1, id_rs2;
    logic [ADDR_W-1:0] id_imm;
    assign id_op  = op_e'(state_q.id_instr[OP_MSB -: FLD_W]);
    assign id_rd  = state_q.id_instr[RD_MSB  -: IDX_W];
    assign id_rs1 = state_q.id_instr[RS1_MSB -: IDX_W];
    assign id_rs2 = state_q.id_instr[RS2_MSB -: IDX_W];
    assign id_imm = state_q.id_instr[ADDR_W-1:0];

    logic              step, stall, id_adv, taken, fetch_ok;
    logic              rf_we;
    logic [DATA_W-1:0] rs1_val, rs2_val, alu_y;
    logic [NDST-1:0]             dst_valid;
    logic [NDST-1:0][IDX_W-1:0]  dst_idx;

    assign step = state_q.phase && !state_q.halt;

    assign dst_valid = {state_q.wb.valid && op_writes_rd(state_q.wb.op),
                        state_q.ex.valid && op_writes_rd(state_q.ex.op),
                        state_q.mr.valid && op_writes_rd(state_q.mr.op)};
    assign dst_idx   = {state_q.wb.rd, state_q.ex.rd, state_q.mr.rd};

    assign rf_we = step && state_q.wb.valid && op_writes_rd(state_q.wb.op);

    stallpipe_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (state_q.wb.rd),
        .wdata (state_q.wb.res),
        .ra1   (id_rs1),
        .ra2   (id_rs2),
        .rd1   (rs1_val),
        .rd2   (rs2_val)
    );

    stallpipe_hazard #(.IDX_W(IDX_W), .NDST(NDST)) u_haz (
        .id_valid  (state_q.id_valid),
        .id_op     (id_op),
        .id_rs1    (id_rs1),
        .id_rs2    (id_rs2),
        .dst_valid (dst_valid),
        .dst_idx   (dst_idx),
        .stall     (stall)
    );

    stallpipe_alu #(.DATA_W(DATA_W)) u_alu (
        .op (state_q.ex.op),
        .a  (state_q.ex.a),
        .b  (state_q.ex.b),
        .y  (alu_y)
    );

    assign id_adv   = state_q.id_valid && !stall;
    assign taken    = ((id_op == OP_BNEZ) && (rs1_val != '0)) ||
                      ((id_op == OP_BEZ)  && (rs1_val == '0));
    // Fetch into an empty decode slot, or behind an ordinary instruction leaving it.
    assign fetch_ok = !state_q.stop &&
                      (!state_q.id_valid ||
                       (id_adv && !op_is_branch(id_op) && (id_op != OP_END)));

    always_comb begin
        state_d = state_q;
        if (!state_q.halt) begin
            state_d.phase = ~state_q.phase;
            state_d.count = state_q.count + 1'b1;
        end
        if (step) begin
            // Execute -> write-back.
            state_d.wb = state_q.ex;
            if (state_q.ex.op != OP_LOAD) state_d.wb.res = alu_y;
            // Memory read -> execute.
            state_d.ex = state_q.mr;
            if (state_q.mr.op == OP_LOAD) state_d.ex.res = dmem_rdata;
            // Decode -> memory read, or a bubble.
            state_d.mr = '0;
            if (id_adv) begin
                state_d.mr.valid = 1'b1;
                state_d.mr.op    = id_op;
                state_d.mr.rd    = id_rd;
                state_d.mr.a     = rs1_val;
                state_d.mr.b     = rs2_val;
                state_d.mr.addr  = id_imm;
                state_d.id_valid = 1'b0;
                if (op_is_branch(id_op) && taken) state_d.pc = id_imm;
                if (id_op == OP_END) state_d.stop = 1'b1;
            end
            if (fetch_ok) begin
                state_d.id_valid = 1'b1;
                state_d.id_instr = imem_data;
                state_d.pc       = state_q.pc + 1'b1;
            end
            if (state_q.wb.valid && (state_q.wb.op == OP_END)) state_d.halt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign imem_addr   = state_q.pc;
    assign dmem_re     = state_q.mr.valid && (state_q.mr.op == OP_LOAD);
    assign dmem_raddr  = state_q.mr.addr;
    assign dmem_we     = step && state_q.mr.valid && (state_q.mr.op == OP_STORE);
    assign dmem_waddr  = state_q.mr.addr;
    assign dmem_wdata  = state_q.mr.a;
    assign halted      = state_q.halt;
    assign cycle_count = state_q.count;
endmodule

// File: rtl/stallpipe_checker.sv
module stallpipe_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic [CNT_W-1:0]  cycle_count,
    input logic              dmem_we,
    input logic [ADDR_W-1:0] imem_addr
);
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_count_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(cycle_count));

    p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> (cycle_count == $past(cycle_count) + CNT_W'(1)));

    // Stores only strike on step edges, which fall on even counts.
    p_store_on_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> cycle_count[0]);

    p_store_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we);

    p_fetch_on_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_addr != $past(imem_addr)) |-> !cycle_count[0]);
endmodule

bind stallpipe_core stallpipe_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halted      (halted),
    .cycle_count (cycle_count),
    .dmem_we     (dmem_we),
    .imem_addr   (imem_addr)
);

// File: tb/stallpipe_core_bench.sv
module stallpipe_core_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [15:0] imem_addr, dmem_raddr, dmem_waddr;
    logic [31:0] imem_data, dmem_rdata, dmem_wdata, cycle_count;
    logic        dmem_re, dmem_we, halted;

    logic [31:0] imem  [0:63];
    logic [31:0] dmem  [0:63];
    logic [31:0] dinit [0:63];

    assign imem_data  = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_raddr[5:0]];

    always @(posedge clk) begin
        if (!rst_n)       dmem <= dinit;
        else if (dmem_we) dmem[dmem_waddr[5:0]] <= dmem_wdata;
    end

    stallpipe_core u_stallpipe_core (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_re(dmem_re), .dmem_raddr(dmem_raddr), .dmem_rdata(dmem_rdata),
        .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
        .halted(halted), .cycle_count(cycle_count)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R1 encoding: op[31:28] rd[27:24] rs1[23:20] rs2[19:16] imm[15:0]
    function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                        input logic [3:0] rs1, input logic [3:0] rs2,
                                        input logic [15:0] imm);
        return {op, rd, rs1, rs2, imm};
    endfunction

    localparam logic [3:0] LOAD = 4'h1, STORE = 4'h2, ADD = 4'h3, XOR = 4'h4,
                           AND = 4'h5, BNEZ = 4'h6, BEZ = 4'h7, ENDI = 4'hF;

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i]  = enc(ENDI, 0, 0, 0, 0);
            dinit[i] = 32'h5A5A_0000 + i;
        end
    endtask

    task automatic start_run();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_to_halt(input string req, input int exp_cycles);
        int waited = 0;
        while (!halted && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check({req, " halt reached (watchdog)"}, {31'd0, halted}, 32'd1);
        check({req, " total cycles"}, cycle_count, exp_cycles);
    endtask

    task automatic t_reset();
        clear_mem();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 halted in reset", {31'd0, halted}, 32'd0);
        check("R12 count in reset", cycle_count, 32'd0);
        check("R12 fetch addr in reset", {16'd0, imem_addr}, 32'd0);
        check("R12 write strobe in reset", {31'd0, dmem_we}, 32'd0);
    endtask

    // Five independent instructions then END: no stall, 2*(5+5) clocks.
    task automatic t_straight();
        clear_mem();
        dinit[16] = 32'd9;
        imem[0] = enc(LOAD, 1, 0, 0, 16);
        imem[1] = enc(LOAD, 2, 0, 0, 17);
        imem[2] = enc(LOAD, 3, 0, 0, 18);
        imem[3] = enc(LOAD, 4, 0, 0, 19);
        imem[4] = enc(STORE, 0, 1, 0, 40);
        imem[5] = enc(ENDI, 0, 0, 0, 0);
        start_run();
        repeat (19) @(negedge clk);
        check("R10 not halted before END retires", {31'd0, halted}, 32'd0);
        check("R11 count one before halt", cycle_count, 32'd19);
        @(negedge clk);
        check("R10 halt rises on schedule", {31'd0, halted}, 32'd1);
        check("R2 R11 no-stall program cycles", cycle_count, 32'd20);
        repeat (6) @(negedge clk);
        check("R11 count frozen after halt", cycle_count, 32'd20);
        check("R3 R4 loaded value stored", dmem[40], 32'd9);
    endtask

    // Back-to-back dependences: write-back and decode meet on one step edge.
    task automatic t_dependent_add();
        clear_mem();
        dinit[16] = 32'd5;
        dinit[17] = 32'd7;
        imem[0] = enc(LOAD, 1, 0, 0, 16);
        imem[1] = enc(LOAD, 2, 0, 0, 17);
        imem[2] = enc(ADD, 3, 1, 2, 0);
        imem[3] = enc(STORE, 0, 3, 0, 32);
        imem[4] = enc(ENDI, 0, 0, 0, 0);
        start_run();
        run_to_halt("R6 R7 dependent chain", 30);
        check("R5 R7 ADD after stall", dmem[32], 32'd12);
    endtask

    task automatic t_xor_and();
        clear_mem();
        dinit[16] = 32'h0F0F;
        dinit[17] = 32'h00FF;
        imem[0] = enc(LOAD, 1, 0, 0, 16);
        imem[1] = enc(LOAD, 2, 0, 0, 17);
        imem[2] = enc(XOR, 3, 1, 2, 0);
        imem[3] = enc(AND, 4, 1, 2, 0);
        imem[4] = enc(STORE, 0, 3, 0, 32);
        imem[5] = enc(STORE, 0, 4, 0, 33);
        imem[6] = enc(ENDI, 0, 0, 0, 0);
        start_run();
        run_to_halt("R6 partial stalls", 32);
        check("R5 XOR result", dmem[32], 32'h0FF0);
        check("R5 AND result", dmem[33], 32'h000F);
    endtask

    task automatic t_bnez_taken();
        clear_mem();
        dinit[16] = 32'd9;
        imem[0] = enc(LOAD, 1, 0, 0, 16);
        imem[1] = enc(BNEZ, 0, 1, 0, 4);
        imem[2] = enc(STORE, 0, 1, 0, 33);
        imem[3] = enc(ENDI, 0, 0, 0, 0);
        imem[4] = enc(STORE, 0, 1, 0, 32);
        imem[5] = enc(ENDI, 0, 0, 0, 0);
        start_run();
        run_to_halt("R8 R9 BNEZ taken", 24);
        check("R8 BNEZ target store", dmem[32], 32'd9);
        check("R9 skipped store has no effect", dmem[33], 32'h5A5A_0021);
    endtask

    task automatic t_bez_both();
        clear_mem();
        dinit[16] = 32'd9;
        dinit[19] = 32'd0;
        imem[0] = enc(LOAD, 1, 0, 0, 16);
        imem[1] = enc(LOAD, 2, 0, 0, 19);
        imem[2] = enc(BEZ, 0, 1, 0, 5);
        imem[3] = enc(BEZ, 0, 2, 0, 6);
        imem[4] = enc(STORE, 0, 1, 0, 33);
        imem[5] = enc(ENDI, 0, 0, 0, 0);
        imem[6] = enc(STORE, 0, 1, 0, 32);
        imem[7] = enc(ENDI, 0, 0, 0, 0);
        start_run();
        run_to_halt("R8 R9 BEZ fall-through then taken", 28);
        check("R8 BEZ taken path store", dmem[32], 32'd9);
        check("R9 BEZ skipped store untouched", dmem[33], 32'h5A5A_0021);
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_straight();
        t_dependent_add();
        t_xor_and();
        t_bnez_taken();
        t_bez_both();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule